// File: doc/BRIEF.md
# Two-Bank Sample FIFO Burst Reader

This block keeps four 8-bit output samples and hands them to a host over a shared serial link. The samples are read two at a time. Storage is split into two banks of two entries each. A producer (the output scaler) pushes samples one per cycle. Entry 1 always holds the oldest sample written since the last completed read, entry 2 the next one, and so on. A full burst read restarts the write position, so each read empties the FIFO.

The host reads with a 24-bit serial command: eight header bits followed by sixteen data bits. The header carries a read flag, a 3-bit chip identifier and a 4-bit address. The address picks a bank. The block then drives the data line with the two entries of that bank, most significant bit first.

The block does not see the raw serial pins. A serial slave front end passes it per-bit strobes, all synchronous to `clk`:
- `ser_rise` marks the edge where the host's bit is sampled.
- `ser_fall` marks the edge where a new bit starts.

The block returns the data bit and a drive enable for the shared pin.

Top module: `fifo_burst_reader`

## Requirements
- R1: After reset `ser_oe`, `ser_dout` and `overflow` are 0 and every entry reads as zero; the first pushed sample goes to entry 1.
- R2: A frame starts when `ser_en` rises, and bit k starts at the (k+1)-th `ser_fall` strobe of that frame. The header is taken from `ser_din` at the `ser_rise` strobe of each of bits 0..7:
  - bit 0 is the read flag and must be 1;
  - bits 1..3 are the identifier, MSB first, and must equal 3'b110;
  - bits 4..7 are address bits a3..a0.
  The header is valid only if a3 = a2 = 0. Bit a1 selects bank 0 or bank 1, and a0 has no effect.
- R3: After a valid header, `ser_oe` goes to 1 in the cycle after the strobe that starts bit 8. `ser_dout` then shows bits 8..23, one per `ser_fall` strobe, as described below. An entry that was not written since reset returns its last written value (zero after reset).
  - Bank 0 sends entry 1 then entry 2.
  - Bank 1 sends entry 3 then entry 4.
  - Each entry is sent MSB first.
- R4: Pushed samples fill entries 1, 2, 3, 4 in arrival order, counted from the last completed read.
- R5: A read is completed when `ser_en` falls after exactly 24 `ser_fall` strobes with a valid header. Completion restarts the write position. A sample pushed in the cycle that detects completion lands in entry 1.
- R6: When all four entries have been filled, further samples are dropped without changing any entry, and `overflow` is set.
- R7: `overflow` stays set until a completed read clears it.
- R8: A frame with an invalid header never drives `ser_oe`. It also leaves the write position and `overflow` unchanged.
- R9: A frame whose enable drops before the 24th strobe leaves the write position and `overflow` unchanged.
- R10: `ser_oe` returns to 0 in the cycle after `ser_en` falls, and `ser_dout` is 0 whenever `ser_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and strobes |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Producer offers a sample this cycle |
| push_data | input | DATA_W | Sample value |
| ser_en | input | 1 | Frame enable from the serial front end |
| ser_rise | input | 1 | One-cycle strobe: sample the host bit |
| ser_fall | input | 1 | One-cycle strobe: a new bit starts |
| ser_din | input | 1 | Host-driven serial data |
| ser_dout | output | 1 | Serial data toward the host |
| ser_oe | output | 1 | Drive enable for the shared data pin |
| overflow | output | 1 | Sticky flag: a sample was dropped while full |

## Verification
The main function is exercised with several fill patterns:
- Partial fill, which exposes stale entries and shows that entry order is counted from the last read.
- Full fill plus one extra sample, which separates a dropped sample from an overwrite.
- A sample pushed in the completion cycle, which shows whether the restart or the push wins.

Header patterns are tried next. Each invalid one (write flag, wrong identifier, a3 set, a2 set) is followed by pushes that reveal whether the write position moved. Setting a0 shows that it is ignored. Aborted frames, both with and without a full FIFO, show the difference between an interrupted read and a completed one.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int HDR_BITS = 8;
    localparam int BANKS    = 2;
    localparam int PER_BANK = 2;
    localparam logic [2:0] DEF_CHIP_ID = 3'b110;

    typedef struct packed {
        logic       rd;
        logic [2:0] id;
        logic [3:0] ad;
    } hdr_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    function automatic logic hdr_ok(input hdr_t h, input logic [2:0] id);
        return h.rd && (h.id == id) && (h.ad[3:2] == 2'b00);
    endfunction

    function automatic logic hdr_bank(input hdr_t h);
        return h.ad[1];
    endfunction

endpackage

// File: rtl/fbr_sample_store.sv
module fbr_sample_store
    import fbr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int PER_BANK = 2,
    parameter int FILL_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DATA_W-1:0]            din,
    input  logic                         clear,
    input  logic                         bank,
    output logic [PER_BANK*DATA_W-1:0]   word,
    output logic [FILL_W-1:0]            fill,
    output logic                         ovf
);
    localparam int NBANK = DEPTH / PER_BANK;
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic [DATA_W-1:0]          ent [DEPTH];
    logic [FILL_W-1:0]          base;
    logic                       wr_ok;
    logic [PER_BANK*DATA_W-1:0] bank_words [NBANK];

    // a completed read rewinds the write position before this cycle's push
    assign base  = clear ? '0 : fill;
    assign wr_ok = push && (clear || (fill != FULL));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_ok && (base == FILL_W'(i))) ent[i] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            ovf  <= 1'b0;
        end else if (clear) begin
            fill <= push ? FILL_W'(1) : '0;
            ovf  <= 1'b0;
        end else if (push) begin
            if (fill == FULL) ovf  <= 1'b1;
            else              fill <= fill + FILL_W'(1);
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            for (genvar j = 0; j < PER_BANK; j++) begin : g_slot
                assign bank_words[b][(PER_BANK-1-j)*DATA_W +: DATA_W] = ent[b*PER_BANK + j];
            end
        end
    endgenerate

    assign word = bank_words[bank];

endmodule

// File: rtl/fbr_ser_frame.sv
module fbr_ser_frame
    import fbr_pkg::*;
#(
    parameter int         FRAME_BITS = 24,
    parameter logic [2:0] CHIP_ID    = DEF_CHIP_ID
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise,
    input  logic fall,
    input  logic din,
    output logic load_o,
    output logic shift_o,
    output logic stop_o,
    output logic done_o,
    output logic bank_o
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST    = CW'(FRAME_BITS);
    localparam logic [CW-1:0] HDR_END = CW'(HDR_BITS);

    phase_t        ph;
    logic [CW-1:0] cnt;
    hdr_t          hdr;
    logic          en_q;
    logic          start;
    logic          fin;

    assign start = en && !en_q;
    assign fin   = !en && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            hdr  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (start) begin
                ph  <= PH_HDR;
                cnt <= '0;
                hdr <= '0;
            end else if (fin) begin
                ph <= PH_IDLE;
            end else begin
                case (ph)
                    PH_HDR: begin
                        if (rise && (cnt != '0)) hdr <= hdr_t'({hdr[HDR_BITS-2:0], din});
                        if (fall) begin
                            cnt <= cnt + CW'(1);
                            if (cnt == HDR_END) ph <= hdr_ok(hdr, CHIP_ID) ? PH_DATA : PH_SKIP;
                        end
                    end
                    PH_DATA: begin
                        if (fall) begin
                            if (cnt == LAST) ph <= PH_SKIP;
                            else             cnt <= cnt + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign load_o  = (ph == PH_HDR) && fall && !start && !fin &&
                     (cnt == HDR_END) && hdr_ok(hdr, CHIP_ID);
    assign shift_o = (ph == PH_DATA) && fall && !start && !fin && (cnt != LAST);
    assign stop_o  = (ph == PH_DATA) && (fin || (fall && (cnt == LAST)));
    assign done_o  = (ph == PH_DATA) && fin && (cnt == LAST);
    assign bank_o  = hdr_bank(hdr);

endmodule

// File: rtl/fbr_tx.sv
module fbr_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic         stop,
    input  logic [W-1:0] word,
    output logic         dout,
    output logic         oe
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (load) begin
            sh <= word;
            oe <= 1'b1;
        end else begin
            if (shift) sh <= {sh[W-2:0], 1'b0};
            if (stop)  oe <= 1'b0;
        end
    end

    assign dout = oe & sh[W-1];

endmodule

// File: rtl/fifo_burst_reader.sv
module fifo_burst_reader
    import fbr_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter logic [2:0] CHIP_ID = DEF_CHIP_ID
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              ser_en,
    input  logic              ser_rise,
    input  logic              ser_fall,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_oe,
    output logic              overflow
);
    localparam int DEPTH      = BANKS * PER_BANK;
    localparam int FILL_W     = $clog2(DEPTH + 1);
    localparam int WORD_W     = PER_BANK * DATA_W;
    localparam int FRAME_BITS = HDR_BITS + WORD_W;

    logic              load_word;
    logic              shift_word;
    logic              stop_tx;
    logic              rd_done;
    logic              bank_sel;
    logic [WORD_W-1:0] bank_word;
    logic [FILL_W-1:0] fill_cnt;

    fbr_ser_frame #(
        .FRAME_BITS (FRAME_BITS),
        .CHIP_ID    (CHIP_ID)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .en      (ser_en),
        .rise    (ser_rise),
        .fall    (ser_fall),
        .din     (ser_din),
        .load_o  (load_word),
        .shift_o (shift_word),
        .stop_o  (stop_tx),
        .done_o  (rd_done),
        .bank_o  (bank_sel)
    );

    fbr_sample_store #(
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .PER_BANK (PER_BANK),
        .FILL_W   (FILL_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push_valid),
        .din   (push_data),
        .clear (rd_done),
        .bank  (bank_sel),
        .word  (bank_word),
        .fill  (fill_cnt),
        .ovf   (overflow)
    );

    fbr_tx #(
        .W (WORD_W)
    ) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (load_word),
        .shift (shift_word),
        .stop  (stop_tx),
        .word  (bank_word),
        .dout  (ser_dout),
        .oe    (ser_oe)
    );

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
    parameter int FILL_W = 3,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_en,
    input logic              ser_fall,
    input logic              ser_oe,
    input logic              push_valid,
    input logic [FILL_W-1:0] fill,
    input logic              overflow,
    input logic              rd_done
);
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH));

    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (rst)
        (push_valid && (fill == FILL_W'(DEPTH)) && !rd_done) |=> overflow);

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !overflow);

    assert_rewind_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !push_valid) |=> (fill == '0));

    assert_rewind_push_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_done && push_valid) |=> (fill == FILL_W'(1)));

    assert_state_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_done && !push_valid) |=> ($stable(fill) && $stable(overflow)));

    assert_oe_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> $past(ser_fall));

    assert_oe_release_R10: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && !$past(ser_en)) |-> !ser_oe);

endmodule

bind fifo_burst_reader fbr_checker #(
    .FILL_W (FILL_W),
    .DEPTH  (DEPTH)
) u_fbr_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_en     (ser_en),
    .ser_fall   (ser_fall),
    .ser_oe     (ser_oe),
    .push_valid (push_valid),
    .fill       (fill_cnt),
    .overflow   (overflow),
    .rd_done    (rd_done)
);

// File: tb/fifo_burst_reader_test.sv
module fifo_burst_reader_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       ser_en = 1'b0;
    logic       ser_rise = 1'b0;
    logic       ser_fall = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_dout;
    logic       ser_oe;
    logic       overflow;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [15:0] w;
        string       tag;
    } exp_t;

    exp_t        exp_q [$];
    logic [15:0] got_q [$];

    logic [7:0] ent_m [4];
    int         fill_m = 0;
    bit         ovf_m  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_burst_reader uut (
        .clk        (clk),
        .rst        (rst),
        .push_valid (push_valid),
        .push_data  (push_data),
        .ser_en     (ser_en),
        .ser_rise   (ser_rise),
        .ser_fall   (ser_fall),
        .ser_din    (ser_din),
        .ser_dout   (ser_dout),
        .ser_oe     (ser_oe),
        .overflow   (overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic push_sample(input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
        if (fill_m < 4) begin
            ent_m[fill_m] = d;
            fill_m++;
        end else begin
            ovf_m = 1'b1;
        end
    endtask

    task automatic run_frame(input logic [7:0] hdr, input int nbits, input bit push_end,
                             input logic [7:0] pd, output logic [15:0] got, output bit oe_seen);
        got     = '0;
        oe_seen = 1'b0;
        @(negedge clk);
        ser_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            ser_fall = 1'b1;
            ser_din  = (k < 8) ? hdr[7-k] : 1'b0;
            @(negedge clk);
            ser_fall = 1'b0;
            @(negedge clk);
            if (k >= 8) got = {got[14:0], ser_dout};
            oe_seen = oe_seen | ser_oe;
            ser_rise = 1'b1;
            @(negedge clk);
            ser_rise = 1'b0;
            @(negedge clk);
        end
        ser_en = 1'b0;
        if (push_end) begin
            push_valid = 1'b1;
            push_data  = pd;
        end
        @(negedge clk);
        push_valid = 1'b0;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R10 oe released after enable drop", ser_oe, 0);
        chk(ser_dout == 1'b0, "R10 data low while undriven", ser_dout, 0);
    endtask

    task automatic read_bank(input bit b, input bit a0, input string tag,
                             input bit push_end, input logic [7:0] pd);
        exp_t        e;
        logic [15:0] got;
        bit          oe_seen;
        e.w   = {ent_m[2*int'(b)], ent_m[2*int'(b)+1]};
        e.tag = tag;
        exp_q.push_back(e);
        run_frame({1'b1, 3'b110, 2'b00, b, a0}, 24, push_end, pd, got, oe_seen);
        got_q.push_back(got);
        chk(oe_seen, "R3 data line driven for valid read", oe_seen, 1);
        fill_m = 0;
        ovf_m  = 1'b0;
        if (push_end) begin
            ent_m[0] = pd;
            fill_m   = 1;
        end
        chk(overflow == ovf_m, "R7 flag after completed read", overflow, ovf_m);
    endtask

    task automatic bad_frame(input logic [7:0] hdr, input string tag);
        logic [15:0] got;
        bit          oe_seen;
        run_frame(hdr, 24, 1'b0, 8'h00, got, oe_seen);
        chk(!oe_seen, tag, oe_seen, 0);
        chk(overflow == ovf_m, "R8 flag kept by invalid frame", overflow, ovf_m);
    endtask

    task automatic abort_frame(input int nbits);
        logic [15:0] got;
        bit          oe_seen;
        run_frame({1'b1, 3'b110, 4'b0000}, nbits, 1'b0, 8'h00, got, oe_seen);
        chk(overflow == ovf_m, "R9 flag kept by aborted frame", overflow, ovf_m);
    endtask

    // scoreboard monitor
    initial begin
        logic [15:0] g;
        exp_t        e;
        forever begin
            wait (got_q.size() != 0);
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 word without expectation", g, 0);
            end else begin
                e = exp_q.pop_front();
                chk(g == e.w, e.tag, g, e.w);
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 4; i++) ent_m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R1 oe after reset", ser_oe, 0);
        chk(ser_dout == 1'b0, "R1 dout after reset", ser_dout, 0);
        chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
        read_bank(1'b0, 1'b0, "R1 entries zero after reset", 1'b0, 8'h00);

        // ordering and bank selection
        push_sample(8'h11); push_sample(8'h22); push_sample(8'h33); push_sample(8'h44);
        read_bank(1'b1, 1'b0, "R4 bank1 carries entries 3 and 4", 1'b0, 8'h00);
        push_sample(8'h55);
        read_bank(1'b0, 1'b1, "R2 a0 ignored, R5 rewind to entry 1", 1'b0, 8'h00);

        // full plus one
        push_sample(8'h61); push_sample(8'h62); push_sample(8'h63); push_sample(8'h64);
        chk(overflow == 1'b0, "R6 no flag when exactly full", overflow, 0);
        push_sample(8'h65);
        chk(overflow == 1'b1, "R6 flag on dropped sample", overflow, 1);
        read_bank(1'b1, 1'b0, "R6 dropped sample absent from bank1", 1'b0, 8'h00);

        // invalid headers
        push_sample(8'h71); push_sample(8'h72);
        bad_frame(8'b0_110_0000, "R8 write flag not driven");
        bad_frame(8'b1_101_0000, "R8 wrong identifier not driven");
        bad_frame(8'b1_110_1000, "R8 a3 set not driven");
        bad_frame(8'b1_110_0100, "R8 a2 set not driven");
        push_sample(8'h73); push_sample(8'h74); push_sample(8'h75);
        bad_frame(8'b1_011_0010, "R8 invalid frame while flagged");
        chk(overflow == 1'b1, "R7 flag sticky across frames", overflow, 1);
        read_bank(1'b1, 1'b0, "R8 write position kept by invalid frames", 1'b0, 8'h00);

        // aborted frames
        push_sample(8'h81);
        abort_frame(12);
        push_sample(8'h82);
        read_bank(1'b0, 1'b0, "R9 abort keeps write position", 1'b0, 8'h00);
        push_sample(8'h91); push_sample(8'h92); push_sample(8'h93); push_sample(8'h94);
        push_sample(8'h95);
        abort_frame(16);
        chk(overflow == 1'b1, "R9 overflow survives abort", overflow, 1);
        read_bank(1'b0, 1'b1, "R9 contents intact after abort", 1'b0, 8'h00);

        // push in the completion cycle
        push_sample(8'hA1); push_sample(8'hA2);
        read_bank(1'b0, 1'b0, "R3 bank0 entries 1 and 2", 1'b1, 8'hB7);
        push_sample(8'hB8);
        read_bank(1'b0, 1'b0, "R5 completion-cycle push lands in entry 1", 1'b0, 8'h00);

        wait (got_q.size() == 0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 all expected words seen", exp_q.size(), 0);
        report();
    end

endmodule